// File: doc/BRIEF.md
# Interrupt Pin Redirection and Destination Resolver

This block watches a set of interrupt input pins. Each pin has its own redirection entry, and those entries arrive as parallel inputs. When an unmasked pin rises, the block captures the event as pending. It then turns the event into an interrupt message, one at a time. The message carries the destination, vector, delivery mode, destination mode, level and trigger, and a bitmap over the processor contexts that should take it. The message leaves through a valid/ready handshake and stays on the outputs until the consumer accepts it.

Context selection follows the destination mode:

- **Physical mode** addresses one context by its index, or all contexts with the broadcast value.
- **Logical mode** AND-matches the destination byte against each context's logical ID byte. These ID bytes are parallel inputs.
- **Lowest-priority delivery** is resolved by a rotating counter that picks one context from the matched set.

Entries in external-interrupt delivery mode take their vector from a legacy controller. The block fetches that vector with a request/acknowledge exchange before it sends the message.

Top module: `irq_redirect`

## Requirements
- R1: A message is generated only on a low-to-high change of a pin. A pin that stays high generates no further message until it has been low for at least one cycle.
- R2: A rising pin whose entry has the mask bit set generates no message.
- R3: Entry layout, per pin, 23 bits:
  - [22] mask
  - [21] trigger
  - [20] polarity
  - [19] destination mode (1 = logical)
  - [18:16] delivery mode
  - [15:8] destination
  - [7:0] vector

  The message copies destination, delivery mode, destination mode, polarity (as `msg_level`) and trigger from the entry.
- R4: In delivery mode 3'b111 (external), the block raises `ext_req` and holds it until `ext_ack`. The message vector is `ext_vec` as sampled with the acknowledge. No message is valid while the request is outstanding.
- R5: In physical mode, destination 8'hFF targets every context. Any other value targets only context number `dest`, and nothing if no context has that number.
- R6: Delivery mode 3'b001 (lowest priority) in physical mode produces a message with `msg_err` = 1 and an empty target bitmap.
- R7: In logical mode, context i is targeted when its logical ID byte AND the destination is nonzero.
- R8: For lowest priority in logical mode with k ≥ 1 matches, the block targets only the (c mod k)-th matched context, counted in ascending index order. c is an 8-bit rotation counter, cleared by reset, which increments after each such message.
- R9: With no logical match, the message carries an empty bitmap and the rotation counter does not advance.
- R10: Pending events are served one message at a time in ascending pin order. An event stays pending until it is taken, and the next event is taken only after the previous message's handshake.
- R11: After reset, `msg_valid` and `ext_req` are 0. While `msg_valid` is high and `msg_ready` is low, the message outputs stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | NUM_PINS | Interrupt input pins |
| entry_flat | input | NUM_PINS*23 | Redirection entries, pin i at bits [i*23 +: 23] |
| ctx_lid | input | NUM_CTX*8 | Logical ID byte of each context, context i at [i*8 +: 8] |
| ext_req | output | 1 | Vector request to legacy controller |
| ext_ack | input | 1 | Vector acknowledge |
| ext_vec | input | 8 | Vector from legacy controller |
| msg_valid | output | 1 | Message valid |
| msg_ready | input | 1 | Consumer ready |
| msg_dest | output | 8 | Message destination |
| msg_vector | output | 8 | Message vector |
| msg_dmode | output | 3 | Delivery mode |
| msg_logical | output | 1 | Destination mode, 1 = logical |
| msg_level | output | 1 | Level (entry polarity) |
| msg_trigger | output | 1 | Trigger mode |
| msg_targets | output | NUM_CTX | Target context bitmap |
| msg_err | output | 1 | Illegal lowest-priority physical combination |

## Verification
The hardest situation to reach is the rotation counter wrapping over a matched set. That set must include a skipped context, and a no-match event must fall between two rotated deliveries; only then does R9's "no advance" become visible.

The stimulus builds this case as follows:
- It programs logical IDs so that a destination matches contexts 0, 1 and 3 but not 2.
- It fires the same lowest-priority entry four times, so the rotation wraps.
- It fires a destination that matches nothing.
- It fires the matching destination again and checks that the selection continues where it left off.

Separately, simultaneous edges with a stalling `msg_ready` check that pending events survive the stalls and are served in order.

// File: rtl/irq_pkg.sv
package irq_pkg;
  parameter int ID_W  = 8;
  parameter int VEC_W = 8;

  localparam logic [2:0] DM_FIXED  = 3'b000;
  localparam logic [2:0] DM_LOWPRI = 3'b001;
  localparam logic [2:0] DM_EXTINT = 3'b111;

  typedef struct packed {
    logic             mask;
    logic             trig;
    logic             pol;
    logic             logical;
    logic [2:0]       dmode;
    logic [ID_W-1:0]  dest;
    logic [VEC_W-1:0] vector;
  } irq_entry_t;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_BUILD, ST_SEND} irq_state_t;
endpackage

// File: rtl/irq_edge_capture.sv
module irq_edge_capture #(
  parameter int NUM_PINS = 8,
  localparam int PIN_IW = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic [NUM_PINS-1:0] mask_vec,
  input  logic              clr_en,
  input  logic [PIN_IW-1:0] clr_idx,
  output logic              pend_any,
  output logic [PIN_IW-1:0] pick_idx
);
  logic [NUM_PINS-1:0] pin_q;
  logic [NUM_PINS-1:0] pend;
  logic [NUM_PINS-1:0] rise;
  logic [NUM_PINS-1:0] clr_oh;

  assign rise = pin_in & ~pin_q;

  genvar g;
  generate
    for (g = 0; g < NUM_PINS; g++) begin : g_clr
      assign clr_oh[g] = clr_en && (clr_idx == PIN_IW'(g));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q <= '0;
      pend  <= '0;
    end else begin
      pin_q <= pin_in;
      pend  <= (pend & ~clr_oh) | (rise & ~mask_vec);
    end
  end

  // lowest pending index wins
  always_comb begin
    pick_idx = '0;
    for (int i = NUM_PINS - 1; i >= 0; i--) begin
      if (pend[i]) pick_idx = PIN_IW'(i);
    end
  end

  assign pend_any = |pend;

  AST_MASK_DROP: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend & $past(rise & mask_vec & ~pend)) == '0)); // R2

  AST_PEND_KEEP: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(pend) & ~pend) & ~$past(clr_oh)) == '0)); // R10
endmodule

// File: rtl/irq_target_resolve.sv
module irq_target_resolve
  import irq_pkg::*;
#(
  parameter int NUM_CTX = 4,
  parameter int ROT_W   = 8
) (
  input  irq_entry_t              ent,
  input  logic [NUM_CTX*ID_W-1:0] ctx_lid,
  input  logic [ROT_W-1:0]        rot,
  output logic [NUM_CTX-1:0]      targets,
  output logic                    err,
  output logic                    advance
);
  localparam int CW = $clog2(NUM_CTX + 1);

  logic [NUM_CTX-1:0] phys_hit;
  logic [NUM_CTX-1:0] log_hit;
  logic [NUM_CTX-1:0] rot_pick;
  logic [CW-1:0]      hit_cnt;
  logic [ROT_W-1:0]   sel_k;
  logic [ROT_W-1:0]   run;
  logic               lowpri;

  genvar g;
  generate
    for (g = 0; g < NUM_CTX; g++) begin : g_hit
      assign phys_hit[g] = (ent.dest == {ID_W{1'b1}}) || (ent.dest == ID_W'(g));
      assign log_hit[g]  = |(ctx_lid[g*ID_W +: ID_W] & ent.dest);
    end
  endgenerate

  always_comb begin
    hit_cnt = '0;
    for (int i = 0; i < NUM_CTX; i++) hit_cnt = hit_cnt + CW'(log_hit[i]);
  end

  assign sel_k = (hit_cnt == '0) ? '0 : (rot % ROT_W'(hit_cnt));

  always_comb begin
    run      = '0;
    rot_pick = '0;
    for (int i = 0; i < NUM_CTX; i++) begin
      if (log_hit[i]) begin
        if (run == sel_k) rot_pick[i] = 1'b1;
        run = run + 1'b1;
      end
    end
  end

  assign lowpri = (ent.dmode == DM_LOWPRI);

  always_comb begin
    err     = 1'b0;
    advance = 1'b0;
    if (!ent.logical) begin
      err     = lowpri;
      targets = lowpri ? '0 : phys_hit;
    end else if (lowpri) begin
      targets = rot_pick;
      advance = (hit_cnt != '0);
    end else begin
      targets = log_hit;
    end
  end
endmodule

// File: rtl/irq_redirect.sv
module irq_redirect
  import irq_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int NUM_CTX  = 4,
  parameter int ROT_W    = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_PINS-1:0]         pin_in,
  input  logic [NUM_PINS*$bits(irq_entry_t)-1:0] entry_flat,
  input  logic [NUM_CTX*ID_W-1:0]     ctx_lid,
  output logic                        ext_req,
  input  logic                        ext_ack,
  input  logic [VEC_W-1:0]            ext_vec,
  output logic                        msg_valid,
  input  logic                        msg_ready,
  output logic [ID_W-1:0]             msg_dest,
  output logic [VEC_W-1:0]            msg_vector,
  output logic [2:0]                  msg_dmode,
  output logic                        msg_logical,
  output logic                        msg_level,
  output logic                        msg_trigger,
  output logic [NUM_CTX-1:0]          msg_targets,
  output logic                        msg_err
);
  localparam int ENT_W  = $bits(irq_entry_t);
  localparam int PIN_IW = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

  irq_entry_t          ent_arr [NUM_PINS];
  logic [NUM_PINS-1:0] mask_vec;
  irq_state_t          state;
  irq_entry_t          cur_ent;
  logic [VEC_W-1:0]    fetched;
  logic [ROT_W-1:0]    rot;
  logic                pend_any;
  logic [PIN_IW-1:0]   pick_idx;
  logic                clr_en;
  logic [NUM_CTX-1:0]  res_targets;
  logic                res_err;
  logic                res_adv;

  genvar g;
  generate
    for (g = 0; g < NUM_PINS; g++) begin : g_ent
      assign ent_arr[g]  = entry_flat[g*ENT_W +: ENT_W];
      assign mask_vec[g] = ent_arr[g].mask;
    end
  endgenerate

  assign clr_en = (state == ST_IDLE) && pend_any;

  irq_edge_capture #(.NUM_PINS(NUM_PINS)) u_edge (
    .clk      (clk),
    .rst      (rst),
    .pin_in   (pin_in),
    .mask_vec (mask_vec),
    .clr_en   (clr_en),
    .clr_idx  (pick_idx),
    .pend_any (pend_any),
    .pick_idx (pick_idx)
  );

  irq_target_resolve #(.NUM_CTX(NUM_CTX), .ROT_W(ROT_W)) u_res (
    .ent     (cur_ent),
    .ctx_lid (ctx_lid),
    .rot     (rot),
    .targets (res_targets),
    .err     (res_err),
    .advance (res_adv)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      cur_ent     <= '0;
      fetched     <= '0;
      rot         <= '0;
      ext_req     <= 1'b0;
      msg_valid   <= 1'b0;
      msg_dest    <= '0;
      msg_vector  <= '0;
      msg_dmode   <= '0;
      msg_logical <= 1'b0;
      msg_level   <= 1'b0;
      msg_trigger <= 1'b0;
      msg_targets <= '0;
      msg_err     <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (pend_any) begin
            cur_ent <= ent_arr[pick_idx];
            if (ent_arr[pick_idx].dmode == DM_EXTINT) begin
              ext_req <= 1'b1;
              state   <= ST_FETCH;
            end else begin
              state   <= ST_BUILD;
            end
          end
        end
        ST_FETCH: begin
          if (ext_ack) begin
            fetched <= ext_vec;
            ext_req <= 1'b0;
            state   <= ST_BUILD;
          end
        end
        ST_BUILD: begin
          msg_valid   <= 1'b1;
          msg_dest    <= cur_ent.dest;
          msg_vector  <= (cur_ent.dmode == DM_EXTINT) ? fetched : cur_ent.vector;
          msg_dmode   <= cur_ent.dmode;
          msg_logical <= cur_ent.logical;
          msg_level   <= cur_ent.pol;
          msg_trigger <= cur_ent.trig;
          msg_targets <= res_targets;
          msg_err     <= res_err;
          if (res_adv) rot <= rot + 1'b1;
          state <= ST_SEND;
        end
        default: begin
          if (msg_ready) begin
            msg_valid <= 1'b0;
            state     <= ST_IDLE;
          end
        end
      endcase
    end
  end

  AST_HOLD_VALID: assert property (@(posedge clk) disable iff (rst)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_targets) && $stable(msg_vector) && $stable(msg_dest)); // R11

  AST_ERR_NO_TARGETS: assert property (@(posedge clk) disable iff (rst)
    msg_valid && msg_err |-> msg_targets == '0); // R6

  AST_LOWPRI_SINGLE: assert property (@(posedge clk) disable iff (rst)
    msg_valid && msg_logical && msg_dmode == DM_LOWPRI |-> $countones(msg_targets) <= 1); // R8

  AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    ext_req && !ext_ack |=> ext_req); // R4

  AST_FETCH_STALL: assert property (@(posedge clk) disable iff (rst)
    ext_req |-> !msg_valid); // R4

  AST_BCAST: assert property (@(posedge clk) disable iff (rst)
    msg_valid && !msg_logical && !msg_err && msg_dest == {ID_W{1'b1}} |-> &msg_targets); // R5
endmodule

// File: tb/test_irq_redirect.sv
module test_irq_redirect;
  localparam int CLK_P = 10;
  localparam int N  = 8;
  localparam int M  = 4;
  localparam int EW = 23;

  typedef struct packed {
    logic [7:0]   dest;
    logic [7:0]   vec;
    logic [2:0]   dm;
    logic         lg;
    logic         lvl;
    logic         trg;
    logic [M-1:0] tg;
    logic         err;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [N-1:0]    pin_in = '0;
  logic [N*EW-1:0] entry_flat;
  logic [M*8-1:0]  ctx_lid;
  logic            ext_req, ext_ack = 1'b0;
  logic [7:0]      ext_vec = 8'h00;
  logic            msg_valid, msg_ready = 1'b0;
  logic [7:0]      msg_dest, msg_vector;
  logic [2:0]      msg_dmode;
  logic            msg_logical, msg_level, msg_trigger, msg_err;
  logic [M-1:0]    msg_targets;

  int    total = 0, bad = 0;
  exp_t  exp_q[$];
  string tag_q[$];
  logic [7:0] br = 8'd0;

  always #(CLK_P/2) clk = ~clk;

  irq_redirect #(.NUM_PINS(N), .NUM_CTX(M), .ROT_W(8)) i_irq_redirect (
    .clk(clk), .rst(rst), .pin_in(pin_in), .entry_flat(entry_flat), .ctx_lid(ctx_lid),
    .ext_req(ext_req), .ext_ack(ext_ack), .ext_vec(ext_vec),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_dest(msg_dest),
    .msg_vector(msg_vector), .msg_dmode(msg_dmode), .msg_logical(msg_logical),
    .msg_level(msg_level), .msg_trigger(msg_trigger), .msg_targets(msg_targets),
    .msg_err(msg_err));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [EW-1:0] mk_ent(bit mask, bit trg, bit pol, bit lg,
                                            logic [2:0] dm, logic [7:0] dst, logic [7:0] v);
    return {mask, trg, pol, lg, dm, dst, v};
  endfunction

  task automatic set_entry(input int idx, input logic [EW-1:0] val);
    entry_flat[idx*EW +: EW] = val;
  endtask

  // independent reference for one accepted event
  function automatic exp_t model(input int pin);
    logic [EW-1:0] e;
    exp_t r;
    int lst[M];
    int n;
    e = entry_flat[pin*EW +: EW];
    r.dest = e[15:8];
    r.dm   = e[18:16];
    r.lg   = e[19];
    r.lvl  = e[20];
    r.trg  = e[21];
    r.vec  = (e[18:16] == 3'b111) ? ext_vec : e[7:0];
    r.err  = 1'b0;
    r.tg   = '0;
    if (!r.lg) begin
      if (r.dm == 3'b001) r.err = 1'b1;
      else if (r.dest == 8'hFF) r.tg = '1;
      else if (r.dest < M) r.tg[r.dest[1:0]] = 1'b1;
    end else begin
      n = 0;
      for (int i = 0; i < M; i++) begin
        if ((ctx_lid[i*8 +: 8] & r.dest) != 8'h00) begin
          lst[n] = i;
          n++;
        end
      end
      if (r.dm == 3'b001) begin
        if (n > 0) begin
          r.tg[lst[int'(br) % n]] = 1'b1;
          br = br + 8'd1;
        end
      end else begin
        for (int i = 0; i < n; i++) r.tg[lst[i]] = 1'b1;
      end
    end
    return r;
  endfunction

  // consumer ready pattern with stalls
  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      msg_ready = (c % 3) != 0;
      c++;
    end
  end

  // legacy vector responder
  initial begin
    int w = 0;
    forever begin
      @(negedge clk);
      if (ext_req && !ext_ack && !rst) begin
        if (w == 3) begin
          chk(msg_valid == 1'b0, "R4 valid during fetch", 64'(msg_valid), 64'd0);
          ext_ack = 1'b1;
          w = 0;
        end else begin
          w++;
        end
      end else begin
        ext_ack = 1'b0;
      end
    end
  end

  // scoreboard monitor
  initial begin
    exp_t  held;
    bit    hold_f = 1'b0;
    exp_t  act;
    exp_t  e;
    string t;
    forever begin
      @(negedge clk);
      #(CLK_P/4);
      if (!rst) begin
        act = {msg_dest, msg_vector, msg_dmode, msg_logical, msg_level, msg_trigger, msg_targets, msg_err};
        if (hold_f) begin
          chk(msg_valid && act == held, "R11 message held while stalled", 64'(act), 64'(held));
          hold_f = 1'b0;
        end
        if (msg_valid && !msg_ready) begin
          held = act;
          hold_f = 1'b1;
        end
        if (msg_valid && msg_ready) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R1/R2/R10 unexpected message", 64'(act), 64'd0);
          end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(act == e, t, 64'(act), 64'(e));
          end
        end
      end
    end
  end

  task automatic drain(input string tag);
    int guard = 0;
    while (exp_q.size() != 0 && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    repeat (6) @(negedge clk);
    chk(exp_q.size() == 0 && !msg_valid, tag, 64'(exp_q.size()), 64'd0);
  endtask

  task automatic fire(input logic [N-1:0] pins, input string tag);
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      if (pins[i] && !pin_in[i] && !entry_flat[i*EW + 22]) begin
        exp_q.push_back(model(i));
        tag_q.push_back(tag);
      end
    end
    pin_in = pin_in | pins;
    repeat (3) @(negedge clk);
    pin_in = pin_in & ~pins;
    drain(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) set_entry(i, mk_ent(1, 0, 0, 0, 3'b000, 8'h00, 8'h00));
    ctx_lid = {8'h02, 8'h04, 8'h03, 8'h01};
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(msg_valid == 1'b0 && ext_req == 1'b0, "R11 reset idle", {62'd0, msg_valid, ext_req}, 64'd0);

    // physical single / broadcast / missing ID
    set_entry(0, mk_ent(0, 0, 1, 0, 3'b000, 8'h02, 8'h31));
    fire(8'h01, "R3/R5 physical single");
    set_entry(1, mk_ent(0, 1, 0, 0, 3'b000, 8'hFF, 8'h42));
    fire(8'h02, "R5 physical broadcast");
    set_entry(1, mk_ent(0, 1, 1, 0, 3'b000, 8'h09, 8'h43));
    fire(8'h02, "R5 physical absent ID");

    // masked entry
    set_entry(2, mk_ent(1, 0, 0, 0, 3'b000, 8'h01, 8'h55));
    fire(8'h04, "R2 masked pin");

    // illegal lowest priority physical
    set_entry(3, mk_ent(0, 0, 0, 0, 3'b001, 8'h01, 8'h66));
    fire(8'h08, "R6 lowpri physical error");

    // logical fixed
    set_entry(0, mk_ent(0, 0, 0, 1, 3'b000, 8'h06, 8'h70));
    fire(8'h01, "R7 logical match");

    // rotation over contexts 0,1,3
    set_entry(0, mk_ent(0, 1, 0, 1, 3'b001, 8'h03, 8'h80));
    for (int k = 0; k < 4; k++) fire(8'h01, "R8 lowpri rotation");
    set_entry(1, mk_ent(0, 0, 0, 1, 3'b001, 8'h08, 8'h81));
    fire(8'h02, "R9 no logical match");
    fire(8'h01, "R9 rotation not advanced");

    // external vector fetch
    ext_vec = 8'hC7;
    set_entry(5, mk_ent(0, 0, 1, 0, 3'b111, 8'h01, 8'h00));
    fire(8'h20, "R4 external vector");

    // simultaneous edges
    set_entry(4, mk_ent(0, 0, 0, 0, 3'b000, 8'h00, 8'hA4));
    set_entry(6, mk_ent(0, 1, 0, 0, 3'b000, 8'h03, 8'hA6));
    set_entry(7, mk_ent(0, 0, 1, 0, 3'b000, 8'h01, 8'hA7));
    fire(8'hD0, "R10 ascending order");

    // held high: one message only, then again after a low period
    set_entry(0, mk_ent(0, 0, 0, 0, 3'b000, 8'h01, 8'h90));
    @(negedge clk);
    exp_q.push_back(model(0));
    tag_q.push_back("R1 first rise");
    pin_in[0] = 1'b1;
    drain("R1 first rise");
    repeat (20) @(negedge clk);
    chk(!msg_valid && exp_q.size() == 0, "R1 held high no repeat", 64'(msg_valid), 64'd0);
    pin_in[0] = 1'b0;
    @(negedge clk);
    fire(8'h01, "R1 rise after low");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule